// File: doc/BRIEF.md
# USB device bus-event interrupt controller

This block sits beside a USB device serial engine and turns bus-level events into sticky, maskable interrupt flags. It watches the decoded line state to find two conditions. Suspend is an idle J level held without a break for three milliseconds of clock. Wake-up is non-idle activity that follows a suspend and outlasts a short glitch filter. It also takes single-cycle strobes from a packet decoder: start-of-frame together with its frame number, end of bus reset, end of resume and upstream resume.

Each event sets its own flag in a read-only status word. Software clears a flag by writing a one to the matching bit of a clear word, and chooses which flags may interrupt by writing an enable word; both words use the status bit positions. Endpoint and DMA interrupt lines from neighbouring blocks are passed straight into the status word and onto the single combined interrupt output. The suspend and wake-up flags clear each other when either one is raised.

Top module: `usb_bus_evt_irq`

## Requirements
- R1: The suspend flag (status bit 0) sets at the clock edge that samples the idle J state (line_state 2'b01) for the CLK_PER_MS*IDLE_MS-th consecutive time. Any other line state restarts the count.
- R2: One unbroken idle period sets the suspend flag only once, so after software clears it the flag stays clear for as long as the line stays J.
- R3: sof_stb sets the start-of-frame flag (status bit 2) and loads sof_frame into frame_num at the same edge; frame_num does not change without the strobe.
- R4: eorst_stb, eorsm_stb and uprsm_stb set the end-of-reset (bit 3), end-of-resume (bit 5) and upstream-resume (bit 6) flags, one edge after the strobe.
- R5: Once a suspend has been detected, the wake-up flag (bit 4) sets when non-J line states last for wake_len consecutive edges (0 counts as 1). Shorter bursts are rejected. With no suspend since the last wake-up, activity is ignored.
- R6: Non-J line states seen while resume_req is high (the device's own upstream resume) never set the wake-up flag, and they restart the filter count.
- R7: Raising the wake-up flag clears the suspend flag, and raising the suspend flag clears the wake-up flag, in the same edge.
- R8: A cycle with clr_wr high clears each flag whose bit in clr_data is one and leaves the others. If a flag is set by hardware in the same cycle, the set wins.
- R9: irq is high when any flag is set together with its enable bit (written by en_wr/en_data, using the status bit positions), or when any ep_irq or dma_irq input is high.
- R10: status reads all zeros after reset. ep_irq[i] appears at bit 12+i and dma_irq[j] at bit 25+j. Bits 1, 7 to 11 and 19 to 24 always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_state | input | 2 | Decoded line state: 00 SE0, 01 J (idle), 10 K, 11 SE1 |
| resume_req | input | 1 | High while the device drives upstream resume |
| wake_len | input | WLEN_W | Wake-up filter length in cycles (0 treated as 1) |
| sof_stb | input | 1 | Start-of-frame packet received |
| sof_frame | input | FNUM_W | Frame number carried by that packet |
| eorst_stb | input | 1 | End of bus reset detected |
| eorsm_stb | input | 1 | End of resume detected |
| uprsm_stb | input | 1 | Upstream resume sent |
| ep_irq | input | EP_N | Endpoint interrupt lines, passed through |
| dma_irq | input | DMA_N | DMA channel interrupt lines, passed through |
| clr_wr | input | 1 | Write strobe for the clear word |
| clr_data | input | 32 | Write-one-to-clear bits, status positions |
| en_wr | input | 1 | Write strobe for the enable word |
| en_data | input | 32 | Enable bits, status positions |
| status | output | 32 | Flag and pass-through status word |
| frame_num | output | FNUM_W | Last received frame number |
| irq | output | 1 | Combined interrupt |

## Verification
A wrong idle count shows as the suspend bit rising one or more edges away from the three-millisecond boundary, or rising a second time during the same idle stretch. The bench sweeps every filter length around its threshold, so a fault in the wake-up filter or its arming shows within a cycle as a wake bit that rises early, rises late or never rises. A broken flag bank, mask register or cross-clear path shows on status or irq at the first edge after the stimulus, and the bench sweeps all 64 enable patterns to expose it.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;

  localparam int unsigned STAT_W = 32;
  localparam int unsigned EVT_N  = 6;

  // event slots inside the flag bank
  localparam int unsigned E_SUSP  = 0;
  localparam int unsigned E_SOF   = 1;
  localparam int unsigned E_EORST = 2;
  localparam int unsigned E_WAKE  = 3;
  localparam int unsigned E_EORSM = 4;
  localparam int unsigned E_UPRSM = 5;

  // status word positions, decoded by software
  localparam int unsigned B_SUSP  = 0;
  localparam int unsigned B_SOF   = 2;
  localparam int unsigned B_EORST = 3;
  localparam int unsigned B_WAKE  = 4;
  localparam int unsigned B_EORSM = 5;
  localparam int unsigned B_UPRSM = 6;
  localparam int unsigned B_EP0   = 12;
  localparam int unsigned B_DMA0  = 25;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  function automatic int unsigned evt_pos(input int unsigned e);
    case (e)
      E_SUSP:  evt_pos = B_SUSP;
      E_SOF:   evt_pos = B_SOF;
      E_EORST: evt_pos = B_EORST;
      E_WAKE:  evt_pos = B_WAKE;
      E_EORSM: evt_pos = B_EORSM;
      default: evt_pos = B_UPRSM;
    endcase
  endfunction

  function automatic logic [EVT_N-1:0] pick_evt(input logic [STAT_W-1:0] w);
    logic [EVT_N-1:0] v;
    for (int e = 0; e < EVT_N; e++) v[e] = w[evt_pos(e)];
    return v;
  endfunction

endpackage

// File: rtl/usb_rst_sync.sv
module usb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_q = sh_q[STAGES-1];
endmodule

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
  parameter int unsigned LIMIT = 144000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_idle,
  output logic hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] SAT  = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    hit    = is_idle && (cnt_q == LAST);
    cnt_d  = is_idle ? cnt_q + 1'b1 : '0;
    cnt_en = is_idle ? (cnt_q != SAT) : (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2: one idle stretch raises at most one detection
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  // R1: a non-idle sample restarts the count
  a_r1_break_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    !is_idle |=> !hit);
endmodule

// File: rtl/usb_wake_filter.sv
module usb_wake_filter #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             active,
  input  logic             resume_req,
  input  logic [LEN_W-1:0] len,
  output logic             hit,
  output logic             armed
);
  logic [LEN_W-1:0] cnt_q, cnt_d, last;
  logic             cond, cnt_en;
  logic             armed_q, armed_d, armed_en;

  always_comb begin
    last     = (len == '0) ? '0 : len - 1'b1;
    cond     = armed_q && active && !resume_req;
    hit      = cond && (cnt_q == last);
    cnt_d    = (cond && !hit) ? cnt_q + 1'b1 : '0;
    cnt_en   = (cnt_d != cnt_q);
    armed_d  = arm;
    armed_en = arm || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (armed_en) armed_q <= armed_d;
  end

  assign armed = armed_q;

  // R5: a wake-up disarms the filter until the next suspend
  a_r5_disarm_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !arm) |=> !armed);
  a_r5_single_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !arm) |=> !hit);
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] xclr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic f_q, f_d, f_en;

    always_comb begin
      f_d  = set[i] || !(clr[i] || xclr[i]);
      f_en = set[i] || clr[i] || xclr[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    f_q <= 1'b0;
      else if (f_en) f_q <= f_d;
    end

    assign q[i] = f_q;

    // R8: hardware set beats a same-cycle software clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set[i] && clr[i]) |=> q[i]);
    // R8: a lone clear drops the flag
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !q[i]);
    // R8: a flag never rises without a set
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !set[i] |=> !$rose(q[i]));
  end
endmodule

// File: rtl/usb_bus_evt_irq.sv
module usb_bus_evt_irq
  import usb_evt_pkg::*;
#(
  parameter int unsigned CLK_PER_MS = 48000,
  parameter int unsigned IDLE_MS    = 3,
  parameter int unsigned WLEN_W     = 3,
  parameter int unsigned FNUM_W     = 11,
  parameter int unsigned EP_N       = 7,
  parameter int unsigned DMA_N      = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        line_state,
  input  logic              resume_req,
  input  logic [WLEN_W-1:0] wake_len,
  input  logic              sof_stb,
  input  logic [FNUM_W-1:0] sof_frame,
  input  logic              eorst_stb,
  input  logic              eorsm_stb,
  input  logic              uprsm_stb,
  input  logic [EP_N-1:0]   ep_irq,
  input  logic [DMA_N-1:0]  dma_irq,
  input  logic              clr_wr,
  input  logic [31:0]       clr_data,
  input  logic              en_wr,
  input  logic [31:0]       en_data,
  output logic [31:0]       status,
  output logic [FNUM_W-1:0] frame_num,
  output logic              irq
);
  localparam int unsigned IDLE_LIMIT = CLK_PER_MS * IDLE_MS;

  logic             rst_q;
  logic             is_idle;
  logic             susp_hit, wake_hit, wake_armed;
  logic [EVT_N-1:0] set_v, clr_v, xclr_v, flag_q;
  logic [EVT_N-1:0] en_q, en_d;
  logic [FNUM_W-1:0] fnum_q, fnum_d;

  usb_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  assign is_idle = (line_state == LS_J);

  usb_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
    .clk     (clk),
    .rst_n   (rst_q),
    .is_idle (is_idle),
    .hit     (susp_hit)
  );

  usb_wake_filter #(.LEN_W(WLEN_W)) u_wake (
    .clk        (clk),
    .rst_n      (rst_q),
    .arm        (susp_hit),
    .active     (!is_idle),
    .resume_req (resume_req),
    .len        (wake_len),
    .hit        (wake_hit),
    .armed      (wake_armed)
  );

  always_comb begin
    set_v          = '0;
    set_v[E_SUSP]  = susp_hit;
    set_v[E_SOF]   = sof_stb;
    set_v[E_EORST] = eorst_stb;
    set_v[E_WAKE]  = wake_hit;
    set_v[E_EORSM] = eorsm_stb;
    set_v[E_UPRSM] = uprsm_stb;

    clr_v          = clr_wr ? pick_evt(clr_data) : '0;

    xclr_v         = '0;
    xclr_v[E_SUSP] = wake_hit;
    xclr_v[E_WAKE] = susp_hit;
  end

  usb_evt_flags #(.N(EVT_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_q),
    .set   (set_v),
    .clr   (clr_v),
    .xclr  (xclr_v),
    .q     (flag_q)
  );

  // enable and frame registers
  always_comb begin
    en_d   = pick_evt(en_data);
    fnum_d = sof_frame;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)     en_q <= '0;
    else if (en_wr) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       fnum_q <= '0;
    else if (sof_stb) fnum_q <= fnum_d;
  end

  // status assembly and interrupt
  always_comb begin
    status = '0;
    for (int e = 0; e < EVT_N; e++) status[evt_pos(e)] = flag_q[e];
    status[B_EP0 +: EP_N]   = ep_irq;
    status[B_DMA0 +: DMA_N] = dma_irq;
  end

  assign frame_num = fnum_q;
  assign irq       = (|(flag_q & en_q)) || (|ep_irq) || (|dma_irq);

  // R3: frame number follows the strobe
  a_r3_frame_load: assert property (@(posedge clk) disable iff (!rst_q)
    sof_stb |=> (frame_num == $past(sof_frame)));
  a_r3_frame_hold: assert property (@(posedge clk) disable iff (!rst_q)
    !sof_stb |=> $stable(frame_num));
  // R6: own upstream resume never counts as wake-up
  a_r6_resume_blocks: assert property (@(posedge clk) disable iff (!rst_q)
    resume_req |=> !$rose(status[B_WAKE]));
  // R7: mutual clearing of suspend and wake-up
  a_r7_wake_clears_susp: assert property (@(posedge clk) disable iff (!rst_q)
    wake_hit |=> (status[B_WAKE] && !status[B_SUSP]));
  a_r7_susp_clears_wake: assert property (@(posedge clk) disable iff (!rst_q)
    susp_hit |=> (status[B_SUSP] && !status[B_WAKE]));
  // R5: wake-up only from an armed filter
  a_r5_needs_arm: assert property (@(posedge clk) disable iff (!rst_q)
    !wake_armed |=> !$rose(status[B_WAKE]));
endmodule

// File: tb/usb_bus_evt_irq_tb.sv
module usb_bus_evt_irq_tb;
  localparam int unsigned CPM   = 8;
  localparam int unsigned IMS   = 3;
  localparam int unsigned LIMIT = CPM * IMS;
  localparam int unsigned WW    = 3;
  localparam int unsigned FW    = 11;

  localparam logic [1:0] L_J = 2'b01;
  localparam logic [1:0] L_K = 2'b10;
  localparam logic [1:0] L_0 = 2'b00;

  localparam logic [31:0] M_SUSP  = 32'h1;
  localparam logic [31:0] M_SOF   = 32'h4;
  localparam logic [31:0] M_EORST = 32'h8;
  localparam logic [31:0] M_WAKE  = 32'h10;
  localparam logic [31:0] M_EORSM = 32'h20;
  localparam logic [31:0] M_UPRSM = 32'h40;
  localparam logic [31:0] M_FREE  = 32'h01F8_0F82;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    line_state;
  logic          resume_req;
  logic [WW-1:0] wake_len;
  logic          sof_stb;
  logic [FW-1:0] sof_frame;
  logic          eorst_stb, eorsm_stb, uprsm_stb;
  logic [6:0]    ep_irq, dma_irq;
  logic          clr_wr, en_wr;
  logic [31:0]   clr_data, en_data;
  logic [31:0]   status;
  logic [FW-1:0] frame_num;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  usb_bus_evt_irq #(
    .CLK_PER_MS(CPM), .IDLE_MS(IMS), .WLEN_W(WW), .FNUM_W(FW), .EP_N(7), .DMA_N(7)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .line_state(line_state), .resume_req(resume_req),
    .wake_len(wake_len), .sof_stb(sof_stb), .sof_frame(sof_frame),
    .eorst_stb(eorst_stb), .eorsm_stb(eorsm_stb), .uprsm_stb(uprsm_stb),
    .ep_irq(ep_irq), .dma_irq(dma_irq), .clr_wr(clr_wr), .clr_data(clr_data),
    .en_wr(en_wr), .en_data(en_data), .status(status), .frame_num(frame_num), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // event order: susp, sof, eorst, wake, eorsm, uprsm -> bits 0,2,3,4,5,6
  function automatic logic [31:0] ev2word(input logic [5:0] e);
    return {25'd0, e[5], e[4], e[3], e[2], e[1], 1'b0, e[0]};
  endfunction

  task automatic clear(input logic [31:0] m);
    clr_data = m; clr_wr = 1'b1;
    step(1);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic set_en(input logic [5:0] e);
    en_data = ev2word(e); en_wr = 1'b1;
    step(1);
    en_wr = 1'b0; en_data = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] fv;
    rst_n = 1'b0; line_state = L_0; resume_req = 1'b0; wake_len = '0;
    sof_stb = 1'b0; sof_frame = '0; eorst_stb = 1'b0; eorsm_stb = 1'b0;
    uprsm_stb = 1'b0; ep_irq = '0; dma_irq = '0; clr_wr = 1'b0; en_wr = 1'b0;
    clr_data = '0; en_data = '0;
    step(3);
    rst_n = 1'b1;
    step(3);

    // R10 reset state
    chk(status == 32'h0, "R10", "reset status", status, 32'h0);
    chk(irq == 1'b0, "R10", "reset irq", {31'd0, irq}, 32'h0);
    chk(frame_num == '0, "R3", "reset frame", {21'd0, frame_num}, 32'h0);

    // R1: broken idle restarts the count, then exact threshold
    line_state = L_J; step(LIMIT - 2);
    line_state = L_K; step(1);
    chk(status[0] == 1'b0, "R1", "idle broken", status, 32'h0);
    line_state = L_J; step(LIMIT - 1);
    chk(status[0] == 1'b0, "R1", "one short of limit", status, 32'h0);
    step(1);
    chk(status == M_SUSP, "R1", "suspend at limit", status, M_SUSP);

    // R2: cleared suspend stays clear during the same idle stretch
    clear(M_SUSP);
    chk(status[0] == 1'b0, "R2", "cleared", status, 32'h0);
    step(2 * LIMIT);
    chk(status[0] == 1'b0, "R2", "no refire", status, 32'h0);

    // R5/R7: wake filter sweep over all lengths
    for (int len = 0; len <= 4; len++) begin
      int eff;
      eff = (len == 0) ? 1 : len;
      wake_len = WW'(len);
      resume_req = 1'b1; line_state = L_K; step(1);
      resume_req = 1'b0; line_state = L_J; step(LIMIT);
      chk(status[0] == 1'b1 && status[4] == 1'b0, "R7", "suspend clears wake",
          status & (M_SUSP | M_WAKE), M_SUSP);
      if (eff > 1) begin
        line_state = L_K; step(eff - 1);
        line_state = L_J; step(1);
        chk(status[4] == 1'b0, "R5", "short burst rejected", status, 32'h0);
      end
      line_state = L_K; step(eff);
      chk(status[4] == 1'b1 && status[0] == 1'b0, "R7", "wake clears suspend",
          status & (M_SUSP | M_WAKE), M_WAKE);
    end
    clear(32'hFFFF_FFFF);
    step(8);
    chk(status[4] == 1'b0, "R5", "not armed after wake", status, 32'h0);

    // R6: own upstream resume does not wake
    wake_len = 3'd2;
    line_state = L_J; step(LIMIT);
    resume_req = 1'b1; line_state = L_K; step(8);
    chk(status == M_SUSP, "R6", "resume ignored", status, M_SUSP);
    resume_req = 1'b0; step(1);
    chk(status[4] == 1'b0, "R6", "filter restarted", status, 32'h0);
    step(1);
    chk(status == M_WAKE, "R6", "wake after resume ends", status, M_WAKE);
    clear(32'hFFFF_FFFF);

    // R3: frame number sweep
    for (int i = 0; i < 6; i++) begin
      logic [FW-1:0] f;
      case (i)
        0: f = 11'h000; 1: f = 11'h001; 2: f = 11'h3FF;
        3: f = 11'h7FF; 4: f = 11'h2AA; default: f = 11'h555;
      endcase
      sof_frame = f; sof_stb = 1'b1; step(1);
      sof_stb = 1'b0;
      chk(frame_num == f && status == M_SOF, "R3", "sof load",
          {5'd0, frame_num, status[15:0]}, {5'd0, f, 16'h4});
      clear(M_SOF);
    end
    sof_frame = 11'h123; step(2);
    chk(frame_num == 11'h555, "R3", "frame holds", {21'd0, frame_num}, 32'h555);

    // R4: single strobes
    eorst_stb = 1'b1; step(1); eorst_stb = 1'b0;
    chk(status == M_EORST, "R4", "end of reset", status, M_EORST);
    clear(32'hFFFF_FFFF);
    eorsm_stb = 1'b1; step(1); eorsm_stb = 1'b0;
    chk(status == M_EORSM, "R4", "end of resume", status, M_EORSM);
    clear(32'hFFFF_FFFF);
    uprsm_stb = 1'b1; step(1); uprsm_stb = 1'b0;
    chk(status == M_UPRSM, "R4", "upstream resume", status, M_UPRSM);
    clear(32'hFFFF_FFFF);

    // R8: set vs clear
    eorst_stb = 1'b1; clr_data = M_EORST; clr_wr = 1'b1; step(1);
    eorst_stb = 1'b0; clr_wr = 1'b0; clr_data = '0;
    chk(status == M_EORST, "R8", "set wins", status, M_EORST);
    clear(~M_EORST);
    chk(status == M_EORST, "R8", "other bits clear leaves it", status, M_EORST);
    clear(M_EORST);
    chk(status == 32'h0, "R8", "own bit clears", status, 32'h0);

    // R9: exhaustive enable sweep
    sof_stb = 1'b1; eorst_stb = 1'b1; eorsm_stb = 1'b1; uprsm_stb = 1'b1; step(1);
    sof_stb = 1'b0; eorst_stb = 1'b0; eorsm_stb = 1'b0; uprsm_stb = 1'b0;
    line_state = L_J; step(LIMIT);
    fv = 6'b110111;
    chk(status == ev2word(fv), "R9", "flag setup", status, ev2word(fv));
    for (int e = 0; e < 64; e++) begin
      set_en(6'(e));
      chk(irq == |(fv & 6'(e)), "R9", "enable mask", {31'd0, irq},
          {31'd0, |(fv & 6'(e))});
    end
    line_state = L_K; step(2);
    chk(status[4] == 1'b1, "R9", "wake raised", status, M_WAKE);
    set_en(6'b001000);
    chk(irq == 1'b1, "R9", "wake enabled", {31'd0, irq}, 32'h1);
    set_en(6'b000001);
    chk(irq == 1'b0, "R9", "suspend cleared not enabled", {31'd0, irq}, 32'h0);

    // R9/R10: pass-through lines
    set_en(6'b000000);
    for (int i = 0; i < 7; i++) begin
      ep_irq = 7'(1 << i); step(1);
      chk(irq == 1'b1 && status[12+i] == 1'b1, "R10", "endpoint bit",
          status, 32'(1) << (12 + i));
    end
    ep_irq = '0;
    for (int i = 0; i < 7; i++) begin
      dma_irq = 7'(1 << i); step(1);
      chk(irq == 1'b1 && status[25+i] == 1'b1, "R10", "dma bit",
          status, 32'(1) << (25 + i));
    end
    dma_irq = '0; step(1);
    chk(irq == 1'b0, "R9", "all masked quiet", {31'd0, irq}, 32'h0);
    ep_irq = 7'h7F; dma_irq = 7'h7F; step(1);
    chk((status & M_FREE) == 32'h0, "R10", "unused bits zero", status & M_FREE, 32'h0);
    chk(status[18:12] == 7'h7F && status[31:25] == 7'h7F, "R10", "pass-through full",
        status, 32'hFE07_F000 | (status & 32'h7F));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule